// File: doc/BRIEF.md
# Next-PC and Branch Condition Unit

This block owns the program counter of a word-addressed 32-bit machine and decides, once per instruction, where execution goes next. The decoder hands it one-cycle strobes for a conditional jump, a jump-and-link, a register return and a trap, together with a 5-bit condition code, a 22-bit target taken from the instruction, a register value, a trap number and the zero and sign flags. The conditional jump carries its condition in the destination-register field, and only the zero and sign flags decide it.

Each cycle the block presents the address of the next instruction, a flag that says whether the flow of control left the straight line, the return address that a jump-and-link writes to its register, and the trap number while a trap is being taken. The PC register inside the block loads the presented next address on every clock edge unless the synchronous reset is asserted. Instruction fetch and trap handling beyond the redirect to a fixed vector belong to other blocks.

Top module: `nextpc_unit`

## Requirements
- R1: On a clock edge with `rst` high the PC register becomes 0 (parameter `RESET_PC`).
- R2: On every clock edge with `rst` low the PC register takes the value that `nextPc` showed just before that edge.
- R3: With no strobe asserted, `taken` is 0 and `nextPc` is `pc + 1`.
- R4: With only `jmpStb` asserted, `taken` follows `condCode`: 0 always; 1 when Z=1; 2 when Z=0; 3 when S=1; 4 when S=1 or Z=1; 5 when S=0 or Z=1; 6 when S=0 and Z=0.
- R5: With only `jmpStb` asserted, condition codes 7 to 31 are never taken and `nextPc` is `pc + 1`.
- R6: A taken jump sets `nextPc` to `jumpAddr` sign-extended from bit 21 to 32 bits.
- R7: `linkValue` is always `pc + 1`; with only `jalStb` asserted, `taken` is 1 and `nextPc` is the sign-extended `jumpAddr`, whatever the flags and condition code.
- R8: With `jrStb` asserted and no trap, `taken` is 1 and `nextPc` equals `regValue`.
- R9: With `trapStb` asserted, `taken` is 1, `nextPc` equals `TRAP_VECTOR` (default 0x100) and `trapCode` equals `trapNum`; without it `trapCode` is 0.
- R10: When several strobes are asserted together, trap wins over register return, which wins over jump-and-link, which wins over the conditional jump.
- R11: Sequential advance from PC 0xFFFFFFFF wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| jmpStb | input | 1 | Conditional jump this instruction |
| jalStb | input | 1 | Jump-and-link this instruction |
| jrStb | input | 1 | Jump to register value this instruction |
| trapStb | input | 1 | Trap this instruction |
| condCode | input | 5 | Jump condition from the destination-register field |
| jumpAddr | input | 22 | Target address field, sign-extended inside |
| regValue | input | 32 | Register contents for the register return |
| trapNum | input | 5 | Trap number |
| flagZ | input | 1 | Zero flag |
| flagS | input | 1 | Sign flag |
| pc | output | 32 | Current PC register |
| nextPc | output | 32 | Address of the next instruction |
| taken | output | 1 | Control flow leaves the sequential path |
| linkValue | output | 32 | Return address for jump-and-link |
| trapCode | output | 5 | Trap number while a trap is taken, else 0 |

## Verification
`nextPc`, `taken`, `linkValue` and `trapCode` are combinational and due in the same cycle as the strobes, so the bench drives inputs on the falling edge and compares them one time unit later, before the next rising edge. `pc` is due one rising edge later, so the reference model advances its own PC on that edge and the comparison happens at the next falling-edge sample. A reset asserted in a cycle is checked the same way, one edge later, against 0.

// File: rtl/npc_pkg.sv
package npc_pkg;
  // Selection strobes from the control to the datapath.
  typedef struct packed {
    logic useAddr;    // load sign-extended instruction address
    logic useReg;     // load register value
    logic useVector;  // load trap vector
    logic taken;      // flow leaves the sequential path
  } npc_ctrl_t;
endpackage

// File: rtl/npc_control.sv
module npc_control
  import npc_pkg::*;
#(
  parameter int COND_W = 5
) (
  input  logic              jmpStb,
  input  logic              jalStb,
  input  logic              jrStb,
  input  logic              trapStb,
  input  logic [COND_W-1:0] condCode,
  input  logic              flagZ,
  input  logic              flagS,
  output npc_ctrl_t         ctrl
);
  localparam int NUM_CODES = 2 ** COND_W;
  localparam int NUM_DEFINED = 7;

  logic [NUM_CODES-1:0] condHit;

  // One hit bit per code; codes beyond the defined set stay low.
  genvar g;
  generate
    for (g = 0; g < NUM_CODES; g++) begin : g_cond
      if (g == 0) begin : g_always
        assign condHit[g] = 1'b1;
      end else if (g == 1) begin : g_eq
        assign condHit[g] = flagZ;
      end else if (g == 2) begin : g_neq
        assign condHit[g] = ~flagZ;
      end else if (g == 3) begin : g_lt
        assign condHit[g] = flagS;
      end else if (g == 4) begin : g_le
        assign condHit[g] = flagS | flagZ;
      end else if (g == 5) begin : g_ge
        assign condHit[g] = ~flagS | flagZ;
      end else if (g == 6) begin : g_gt
        assign condHit[g] = ~flagS & ~flagZ;
      end else begin : g_undef
        assign condHit[g] = (g < NUM_DEFINED);
      end
    end
  endgenerate

  logic condOk;
  assign condOk = condHit[condCode];

  // Fixed priority: trap, register return, link jump, conditional jump.
  always_comb begin
    ctrl = '0;
    if (trapStb) begin
      ctrl.useVector = 1'b1;
      ctrl.taken     = 1'b1;
    end else if (jrStb) begin
      ctrl.useReg = 1'b1;
      ctrl.taken  = 1'b1;
    end else if (jalStb) begin
      ctrl.useAddr = 1'b1;
      ctrl.taken   = 1'b1;
    end else if (jmpStb && condOk) begin
      ctrl.useAddr = 1'b1;
      ctrl.taken   = 1'b1;
    end
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int               XLEN        = 32,
  parameter int               ADDR_W      = 22,
  parameter int               TRAP_W      = 5,
  parameter logic [XLEN-1:0]  TRAP_VECTOR = 32'h0000_0100,
  parameter logic [XLEN-1:0]  RESET_PC    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  npc_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] jumpAddr,
  input  logic [XLEN-1:0]   regValue,
  input  logic [TRAP_W-1:0] trapNum,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   nextPc,
  output logic [XLEN-1:0]   linkValue,
  output logic [TRAP_W-1:0] trapCode
);
  localparam int EXT_W = XLEN - ADDR_W;

  logic [XLEN-1:0] pcReg;
  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] targetPc;

  assign seqPc    = pcReg + XLEN'(1);
  assign targetPc = {{EXT_W{jumpAddr[ADDR_W-1]}}, jumpAddr};

  always_comb begin
    if (ctrl.useVector)    nextPc = TRAP_VECTOR;
    else if (ctrl.useReg)  nextPc = regValue;
    else if (ctrl.useAddr) nextPc = targetPc;
    else                   nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= RESET_PC;
    else     pcReg <= nextPc;
  end

  assign pc        = pcReg;
  assign linkValue = seqPc;
  assign trapCode  = ctrl.useVector ? trapNum : '0;
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import npc_pkg::*;
#(
  parameter int               XLEN        = 32,
  parameter int               ADDR_W      = 22,
  parameter int               COND_W      = 5,
  parameter int               TRAP_W      = 5,
  parameter logic [XLEN-1:0]  TRAP_VECTOR = 32'h0000_0100,
  parameter logic [XLEN-1:0]  RESET_PC    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jmpStb,
  input  logic              jalStb,
  input  logic              jrStb,
  input  logic              trapStb,
  input  logic [COND_W-1:0] condCode,
  input  logic [ADDR_W-1:0] jumpAddr,
  input  logic [XLEN-1:0]   regValue,
  input  logic [TRAP_W-1:0] trapNum,
  input  logic              flagZ,
  input  logic              flagS,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   nextPc,
  output logic              taken,
  output logic [XLEN-1:0]   linkValue,
  output logic [TRAP_W-1:0] trapCode
);
  npc_ctrl_t ctrl;

  npc_control #(.COND_W(COND_W)) u_control (
    .jmpStb  (jmpStb),
    .jalStb  (jalStb),
    .jrStb   (jrStb),
    .trapStb (trapStb),
    .condCode(condCode),
    .flagZ   (flagZ),
    .flagS   (flagS),
    .ctrl    (ctrl)
  );

  npc_datapath #(
    .XLEN       (XLEN),
    .ADDR_W     (ADDR_W),
    .TRAP_W     (TRAP_W),
    .TRAP_VECTOR(TRAP_VECTOR),
    .RESET_PC   (RESET_PC)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .jumpAddr (jumpAddr),
    .regValue (regValue),
    .trapNum  (trapNum),
    .pc       (pc),
    .nextPc   (nextPc),
    .linkValue(linkValue),
    .trapCode (trapCode)
  );

  assign taken = ctrl.taken;
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
  parameter int               XLEN        = 32,
  parameter int               ADDR_W      = 22,
  parameter int               COND_W      = 5,
  parameter int               TRAP_W      = 5,
  parameter logic [XLEN-1:0]  TRAP_VECTOR = 32'h0000_0100,
  parameter logic [XLEN-1:0]  RESET_PC    = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              jmpStb,
  input logic              jalStb,
  input logic              jrStb,
  input logic              trapStb,
  input logic [COND_W-1:0] condCode,
  input logic [ADDR_W-1:0] jumpAddr,
  input logic [XLEN-1:0]   regValue,
  input logic [TRAP_W-1:0] trapNum,
  input logic              flagZ,
  input logic              flagS,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   nextPc,
  input logic              taken,
  input logic [XLEN-1:0]   linkValue,
  input logic [TRAP_W-1:0] trapCode
);
  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  assert_reset_pc_R1: assert property (@(posedge clk)
    seenEdge && $past(rst) |-> pc == RESET_PC);

  assert_pc_follows_R2: assert property (@(posedge clk) disable iff (rst)
    seenEdge && !$past(rst) |-> pc == $past(nextPc));

  assert_sequential_R3: assert property (@(posedge clk) disable iff (rst)
    !jmpStb && !jalStb && !jrStb && !trapStb |-> !taken && nextPc == pc + XLEN'(1));

  assert_undef_cond_R5: assert property (@(posedge clk) disable iff (rst)
    jmpStb && !jalStb && !jrStb && !trapStb && condCode >= COND_W'(7) |-> !taken);

  assert_link_R7: assert property (@(posedge clk) disable iff (rst)
    linkValue == pc + XLEN'(1));

  assert_reg_return_R8: assert property (@(posedge clk) disable iff (rst)
    jrStb && !trapStb |-> taken && nextPc == regValue);

  assert_trap_R9: assert property (@(posedge clk) disable iff (rst)
    trapStb |-> taken && nextPc == TRAP_VECTOR && trapCode == trapNum);

  assert_no_trap_code_R9: assert property (@(posedge clk) disable iff (rst)
    !trapStb |-> trapCode == '0);
endmodule

bind nextpc_unit nextpc_unit_chk #(
  .XLEN(XLEN), .ADDR_W(ADDR_W), .COND_W(COND_W), .TRAP_W(TRAP_W),
  .TRAP_VECTOR(TRAP_VECTOR), .RESET_PC(RESET_PC)
) u_chk (
  .clk(clk), .rst(rst), .jmpStb(jmpStb), .jalStb(jalStb), .jrStb(jrStb),
  .trapStb(trapStb), .condCode(condCode), .jumpAddr(jumpAddr),
  .regValue(regValue), .trapNum(trapNum), .flagZ(flagZ), .flagS(flagS),
  .pc(pc), .nextPc(nextPc), .taken(taken), .linkValue(linkValue),
  .trapCode(trapCode)
);

// File: tb/tb_nextpc_unit.sv
`timescale 1ns/1ps
module tb_nextpc_unit;
  localparam logic [31:0] VEC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst;
  logic        jmpStb, jalStb, jrStb, trapStb;
  logic [4:0]  condCode;
  logic [21:0] jumpAddr;
  logic [31:0] regValue;
  logic [4:0]  trapNum;
  logic        flagZ, flagS;
  logic [31:0] pc, nextPc, linkValue;
  logic        taken;
  logic [4:0]  trapCode;

  int checks = 0;
  int failures = 0;
  logic [31:0] modelPc;
  bit lastRst;

  always #2 clk = ~clk;

  nextpc_unit dut (
    .clk(clk), .rst(rst), .jmpStb(jmpStb), .jalStb(jalStb), .jrStb(jrStb),
    .trapStb(trapStb), .condCode(condCode), .jumpAddr(jumpAddr),
    .regValue(regValue), .trapNum(trapNum), .flagZ(flagZ), .flagS(flagS),
    .pc(pc), .nextPc(nextPc), .taken(taken), .linkValue(linkValue),
    .trapCode(trapCode)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit condTrue(input logic [4:0] c, input bit z, input bit s);
    case (c)
      5'd0: return 1'b1;
      5'd1: return z;
      5'd2: return !z;
      5'd3: return s;
      5'd4: return s || z;
      5'd5: return !s || z;
      5'd6: return !s && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input bit j, input bit jl, input bit r, input bit t,
                      input logic [4:0] c, input logic [21:0] a,
                      input logic [31:0] rv, input logic [4:0] tn,
                      input bit z, input bit s, input bit rs);
    logic [31:0] expNext;
    bit expTaken;
    string tag;
    int nStb;
    @(negedge clk);
    jmpStb = j; jalStb = jl; jrStb = r; trapStb = t;
    condCode = c; jumpAddr = a; regValue = rv; trapNum = tn;
    flagZ = z; flagS = s; rst = rs;
    #1;
    nStb = int'(j) + int'(jl) + int'(r) + int'(t);
    if (t) begin
      expNext = VEC; expTaken = 1'b1; tag = "R9";
    end else if (r) begin
      expNext = rv; expTaken = 1'b1; tag = "R8";
    end else if (jl || (j && condTrue(c, z, s))) begin
      expNext = {{10{a[21]}}, a}; expTaken = 1'b1;
      tag = jl ? "R7" : "R6";
    end else begin
      expNext = modelPc + 32'd1; expTaken = 1'b0;
      if (j) tag = (c >= 5'd7) ? "R5" : "R4";
      else if (modelPc == 32'hFFFF_FFFF) tag = "R11";
      else tag = "R3";
    end
    if (nStb > 1) tag = "R10";
    if (j && !jl && !r && !t && c < 5'd7) tag = "R4";
    check(lastRst ? "R1" : "R2", "pc", pc, modelPc);
    check(tag, "nextPc", nextPc, expNext);
    check(tag, "taken", {31'b0, taken}, {31'b0, expTaken});
    check("R7", "linkValue", linkValue, modelPc + 32'd1);
    check("R9", "trapCode", {27'b0, trapCode}, t ? {27'b0, tn} : 32'b0);
    @(posedge clk);
    modelPc = rs ? 32'h0 : expNext;
    lastRst = rs;
  endtask

  task automatic idle(input bit rs);
    step(0, 0, 0, 0, 5'd0, 22'h0, 32'h0, 5'd0, 0, 0, rs);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    jmpStb = 0; jalStb = 0; jrStb = 0; trapStb = 0;
    condCode = '0; jumpAddr = '0; regValue = '0; trapNum = '0;
    flagZ = 0; flagS = 0;
    modelPc = '0;
    lastRst = 1'b1;
    repeat (2) @(posedge clk);
    // R1: reset state, then sequential advance (R3)
    idle(1);
    repeat (3) idle(0);
    // R4/R5/R6: every condition code under every flag pair
    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 4; f++) begin
        step(1, 0, 0, 0, 5'(c), 22'h0000_40 + 22'(c), 32'h0, 5'd0,
             f[0], f[1], 0);
        idle(0);
      end
    end
    // R6: negative target sign-extends
    step(1, 0, 0, 0, 5'd0, 22'h3F_FFF0, 32'h0, 5'd0, 0, 0, 0);
    idle(0);
    // R7: link jump ignores flags and condition code
    step(0, 1, 0, 0, 5'd9, 22'h00_1234, 32'h0, 5'd0, 1, 1, 0);
    step(0, 1, 0, 0, 5'd2, 22'h20_0000, 32'h0, 5'd0, 1, 0, 0);
    // R8: register return
    step(0, 0, 1, 0, 5'd0, 22'h0, 32'hDEAD_BEEF, 5'd0, 0, 0, 0);
    // R9: trap
    step(0, 0, 0, 1, 5'd0, 22'h0, 32'h0, 5'd17, 0, 0, 0);
    idle(0);
    // R10: priority combinations
    step(1, 1, 1, 1, 5'd0, 22'h0000_77, 32'h0000_5555, 5'd3, 0, 0, 0);
    step(1, 1, 1, 0, 5'd0, 22'h0000_77, 32'h0000_5555, 5'd3, 0, 0, 0);
    step(1, 1, 0, 0, 5'd7, 22'h0000_99, 32'h0, 5'd0, 0, 0, 0);
    step(1, 0, 1, 0, 5'd9, 22'h0000_99, 32'h0000_AAAA, 5'd0, 0, 0, 0);
    // R11: wrap from the top of the address space
    step(0, 0, 1, 0, 5'd0, 22'h0, 32'hFFFF_FFFF, 5'd0, 0, 0, 0);
    idle(0);
    idle(0);
    // R1: reset mid-run
    step(0, 0, 1, 0, 5'd0, 22'h0, 32'h1234_0000, 5'd0, 0, 0, 0);
    step(1, 1, 0, 0, 5'd0, 22'h0000_55, 32'h0, 5'd0, 0, 0, 1);
    idle(0);
    // Mixed pseudo-random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rnd;
      rnd = $urandom;
      step(rnd[0] | rnd[1], rnd[2] & rnd[3], rnd[4] & rnd[5] & rnd[6],
           rnd[7] & rnd[8] & rnd[9], rnd[14:10], 22'($urandom),
           $urandom, rnd[19:15], rnd[20], rnd[21], rnd[31:26] == 6'd0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule